// File: doc/BRIEF.md
# I2C Master START Generator with Stuck-Clock Recovery

This block is the front end of an I2C master. On a host request it raises a busy status, waits for the bus to become free, drives a START condition and the first low clock phase. It then hands the latched address, direction and byte count to a downstream data engine with a one-cycle go pulse. It keeps both open-drain lines low until that engine releases them.

A device outside the master may be holding SCL low when the request arrives. The block must not hang in that case. The START sequencer simply waits until the filtered SCL reads high. The hold-phase counter pauses while SCL is pulled low and resumes when it is released. A programmable low-clock timeout ends the wait with a sticky, interrupt-raising error flag. When the timeout fires, busy is cleared and both lines are released.

The sampled lines are synchronised and pass through a programmable glitch filter. An optional idle-probe mode requires the bus to be free for a whole timeout period before START. A nine-pulse recovery sequence clocks out a slave that is stuck holding SDA. Dropping the enable input acts as a soft reset.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset both line drivers (`scl_oe_o`, `sda_oe_o`, 1 = pull low) are off, and `busy_o`, `tout_o`, `berr_o`, `irq_o` and `xfer_go_o` are 0.
- R2: A request (`req_start_i` high while `enable_i` is high and the block is idle) sets `busy_o` at the next clock edge, even if SCL is held low. SDA is not driven while filtered SCL reads low before START.
- R3: Once filtered SCL and SDA are both high, SDA is pulled low while SCL is released, forming a START condition. After the hold phase and a LOW_CYC-clock SCL low phase, `xfer_go_o` pulses for one cycle with the request's address, direction and count on the `xfer_*` outputs. Both lines then stay low until `eng_release_i`, which releases them and clears busy.
- R4: The hold phase counts HOLD_CYC clocks during which filtered SCL is high. The count pauses while SCL is pulled low externally, so with no interference SCL is pulled low exactly HOLD_CYC clocks after SDA.
- R5: If SCL stays low (not driven by the block) for `to_limit_i` ticks of TICK_DIV clocks while waiting or holding, `tout_o` and `irq_o` are set. In the same edge, busy clears and both lines are released.
- R6: `to_limit_i` = 0 disables the timeout. SCL may then be held low for any length of time without a flag, and the request completes once SCL is released.
- R7: If SDA stays low while SCL is high during the wait for `to_limit_i` ticks, `berr_o` is set instead of `tout_o`, with the same release of the bus.
- R8: `tout_o` and `berr_o` hold until a clock with `clr_tout_i` / `clr_berr_i` high. A set and a clear in the same cycle leave the flag set.
- R9: With `enable_i` low, the next edge returns the block to idle with both lines released, and `busy_o` and both flags cleared.
- R10: A `recover_i` pulse while idle produces exactly RCV_PULSES (9) SCL low pulses with SDA never driven, and `busy_o` is high until the sequence ends.
- R11: A filtered line takes a new level only after the synchronised input has differed from it for `filt_len_i`+1 consecutive clocks. With `filt_len_i` = 8, a 3-clock release of a held SCL starts nothing.
- R12: With `idle_probe_i` high, START waits until both lines have been continuously high for `to_limit_i` ticks.
- R13: Requests arriving while busy are ignored. The `xfer_*` values keep those of the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Block enable; low acts as soft reset |
| req_start_i | input | 1 | Transfer request strobe |
| req_read_i | input | 1 | Direction of the request, 1 = read |
| req_addr_i | input | ADDR_W | Target address of the request |
| req_nbytes_i | input | NB_W | Byte count of the request |
| recover_i | input | 1 | Starts the nine-pulse recovery sequence |
| eng_release_i | input | 1 | Data engine gives the lines back |
| filt_len_i | input | FILT_W | Glitch filter length in clocks |
| to_limit_i | input | LIM_W | Timeout / idle-probe limit in ticks, 0 disables |
| idle_probe_i | input | 1 | Require a full idle period before START |
| clr_tout_i | input | 1 | Clears the timeout flag |
| clr_berr_i | input | 1 | Clears the bus error flag |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| busy_o | output | 1 | Block owns or waits for the bus |
| tout_o | output | 1 | Sticky SCL-low timeout flag |
| berr_o | output | 1 | Sticky stuck-SDA bus error flag |
| irq_o | output | 1 | Either error flag is set |
| xfer_go_o | output | 1 | One-cycle handoff pulse to the data engine |
| xfer_read_o | output | 1 | Latched direction |
| xfer_addr_o | output | ADDR_W | Latched address |
| xfer_nbytes_o | output | NB_W | Latched byte count |

## Verification
Two of this block's functions can meet on one clock edge: the timeout expiry setting `tout_o`, and a host clear of that flag. The bench holds SCL low with `clr_tout_i` asserted throughout the request. It samples at the first clock where busy has dropped and expects the flag to read 1 there, and to read 0 one clock later. Sweeps across filter lengths and release delays vary when SCL comes free relative to the tick grid. For each case, the bench judges the START condition, the hold spacing and the handed-over fields.

// File: rtl/i2c_sg_pkg.sv
package i2c_sg_pkg;
   typedef enum logic [2:0] {
      SG_IDLE,
      SG_WAIT,
      SG_HOLD,
      SG_LOW,
      SG_OWN,
      SG_RCV_LO,
      SG_RCV_HI
   } sg_state_e;
endpackage

// File: rtl/i2c_sg_filter.sv
module i2c_sg_filter #(
   parameter int LEN_W   = 4,
   parameter bit RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raw_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             filt_o
);
   logic [1:0]       sync_q;
   logic [LEN_W-1:0] cnt_q;
   logic             filt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {2{RST_VAL}};
         cnt_q  <= '0;
         filt_q <= RST_VAL;
      end else begin
         sync_q <= {sync_q[0], raw_i};
         if (sync_q[1] == filt_q) begin
            cnt_q <= '0;
         end else if (cnt_q >= len_i) begin
            filt_q <= sync_q[1];
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign filt_o = filt_q;
endmodule

// File: rtl/i2c_sg_tick.sv
module i2c_sg_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_direct
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      div_q <= '0;
            else if (div_q == DW'(DIV - 1))  div_q <= '0;
            else                             div_q <= div_q + 1'b1;
         end
         assign tick_o = (div_q == DW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/i2c_sg_watch.sv
module i2c_sg_watch #(
   parameter int LIM_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             blk_en_i,
   input  logic             free_en_i,
   input  logic [LIM_W-1:0] limit_i,
   output logic             expired_o,
   output logic             free_ok_o
);
   logic [LIM_W-1:0] blk_q;
   logic [LIM_W-1:0] free_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_q  <= '0;
         free_q <= '0;
      end else begin
         if (!blk_en_i)                    blk_q <= '0;
         else if (tick_i && (blk_q != '1)) blk_q <= blk_q + 1'b1;
         if (!free_en_i)                    free_q <= '0;
         else if (tick_i && (free_q != '1)) free_q <= free_q + 1'b1;
      end
   end

   assign expired_o = blk_en_i && (limit_i != '0) && (blk_q >= limit_i);
   assign free_ok_o = free_en_i && (free_q >= limit_i);
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen #(
   parameter int ADDR_W     = 7,
   parameter int NB_W       = 8,
   parameter int FILT_W     = 4,
   parameter int LIM_W      = 12,
   parameter int TICK_DIV   = 4,
   parameter int HOLD_CYC   = 8,
   parameter int LOW_CYC    = 8,
   parameter int RCV_PULSES = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable_i,
   input  logic              req_start_i,
   input  logic              req_read_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [NB_W-1:0]   req_nbytes_i,
   input  logic              recover_i,
   input  logic              eng_release_i,
   input  logic [FILT_W-1:0] filt_len_i,
   input  logic [LIM_W-1:0]  to_limit_i,
   input  logic              idle_probe_i,
   input  logic              clr_tout_i,
   input  logic              clr_berr_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe_o,
   output logic              sda_oe_o,
   output logic              busy_o,
   output logic              tout_o,
   output logic              berr_o,
   output logic              irq_o,
   output logic              xfer_go_o,
   output logic              xfer_read_o,
   output logic [ADDR_W-1:0] xfer_addr_o,
   output logic [NB_W-1:0]   xfer_nbytes_o
);
   import i2c_sg_pkg::*;

   localparam int PH_MAX  = (HOLD_CYC > LOW_CYC) ? HOLD_CYC : LOW_CYC;
   localparam int PH_W    = $clog2(PH_MAX + 1);
   localparam int PULSE_W = $clog2(RCV_PULSES + 1);
   localparam int N_LINES = 2;

   generate
      if (HOLD_CYC < 2) begin : g_bad_hold
         $error("HOLD_CYC must be at least 2");
      end
      if (LOW_CYC < 2) begin : g_bad_low
         $error("LOW_CYC must be at least 2");
      end
      if (RCV_PULSES < 1) begin : g_bad_rcv
         $error("RCV_PULSES must be at least 1");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (FILT_W < 1 || FILT_W > 8) begin : g_bad_filt
         $error("FILT_W must lie in 1..8");
      end
   endgenerate

   // line conditioning: index 0 = SCL, index 1 = SDA
   logic [N_LINES-1:0] raw_v;
   logic [N_LINES-1:0] filt_v;
   assign raw_v = {sda_i, scl_i};

   generate
      for (genvar li = 0; li < N_LINES; li++) begin : g_line
         i2c_sg_filter #(.LEN_W(FILT_W), .RST_VAL(1'b1)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_v[li]),
            .len_i  (filt_len_i),
            .filt_o (filt_v[li])
         );
      end
   endgenerate

   logic scl_f, sda_f;
   assign scl_f = filt_v[0];
   assign sda_f = filt_v[1];

   logic tick;
   i2c_sg_tick #(.DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   sg_state_e          state_q;
   logic [PH_W-1:0]    ph_q;
   logic [PULSE_W-1:0] pulse_q;
   logic               blk_en, free_en, expired, free_ok, start_ok;

   assign blk_en  = ((state_q == SG_WAIT) && !(scl_f && sda_f)) ||
                    ((state_q == SG_HOLD) && !scl_f) ||
                    ((state_q == SG_RCV_HI) && !scl_f);
   assign free_en = (state_q == SG_WAIT) && scl_f && sda_f;

   i2c_sg_watch #(.LIM_W(LIM_W)) u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .blk_en_i  (blk_en),
      .free_en_i (free_en),
      .limit_i   (to_limit_i),
      .expired_o (expired),
      .free_ok_o (free_ok)
   );

   assign start_ok = idle_probe_i ? free_ok : (scl_f && sda_f);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q       <= SG_IDLE;
         ph_q          <= '0;
         pulse_q       <= '0;
         scl_oe_o      <= 1'b0;
         sda_oe_o      <= 1'b0;
         busy_o        <= 1'b0;
         tout_o        <= 1'b0;
         berr_o        <= 1'b0;
         xfer_go_o     <= 1'b0;
         xfer_read_o   <= 1'b0;
         xfer_addr_o   <= '0;
         xfer_nbytes_o <= '0;
      end else if (!enable_i) begin
         state_q   <= SG_IDLE;
         ph_q      <= '0;
         pulse_q   <= '0;
         scl_oe_o  <= 1'b0;
         sda_oe_o  <= 1'b0;
         busy_o    <= 1'b0;
         tout_o    <= 1'b0;
         berr_o    <= 1'b0;
         xfer_go_o <= 1'b0;
      end else begin
         xfer_go_o <= 1'b0;
         if (clr_tout_i) tout_o <= 1'b0;
         if (clr_berr_i) berr_o <= 1'b0;
         if (expired) begin
            state_q  <= SG_IDLE;
            scl_oe_o <= 1'b0;
            sda_oe_o <= 1'b0;
            busy_o   <= 1'b0;
            if (!scl_f) tout_o <= 1'b1;
            else        berr_o <= 1'b1;
         end else begin
            unique case (state_q)
               SG_IDLE: begin
                  if (req_start_i) begin
                     xfer_read_o   <= req_read_i;
                     xfer_addr_o   <= req_addr_i;
                     xfer_nbytes_o <= req_nbytes_i;
                     busy_o        <= 1'b1;
                     state_q       <= SG_WAIT;
                  end else if (recover_i) begin
                     busy_o   <= 1'b1;
                     scl_oe_o <= 1'b1;
                     ph_q     <= '0;
                     pulse_q  <= '0;
                     state_q  <= SG_RCV_LO;
                  end
               end
               SG_WAIT: begin
                  if (start_ok) begin
                     sda_oe_o <= 1'b1;
                     ph_q     <= '0;
                     state_q  <= SG_HOLD;
                  end
               end
               SG_HOLD: begin
                  if (scl_f) begin
                     if (ph_q == PH_W'(HOLD_CYC - 1)) begin
                        scl_oe_o <= 1'b1;
                        ph_q     <= '0;
                        state_q  <= SG_LOW;
                     end else begin
                        ph_q <= ph_q + 1'b1;
                     end
                  end
               end
               SG_LOW: begin
                  if (ph_q == PH_W'(LOW_CYC - 1)) begin
                     xfer_go_o <= 1'b1;
                     ph_q      <= '0;
                     state_q   <= SG_OWN;
                  end else begin
                     ph_q <= ph_q + 1'b1;
                  end
               end
               SG_OWN: begin
                  if (eng_release_i) begin
                     scl_oe_o <= 1'b0;
                     sda_oe_o <= 1'b0;
                     busy_o   <= 1'b0;
                     state_q  <= SG_IDLE;
                  end
               end
               SG_RCV_LO: begin
                  if (ph_q == PH_W'(LOW_CYC - 1)) begin
                     scl_oe_o <= 1'b0;
                     ph_q     <= '0;
                     state_q  <= SG_RCV_HI;
                  end else begin
                     ph_q <= ph_q + 1'b1;
                  end
               end
               SG_RCV_HI: begin
                  if (scl_f) begin
                     if (ph_q == PH_W'(HOLD_CYC - 1)) begin
                        ph_q <= '0;
                        if (pulse_q == PULSE_W'(RCV_PULSES - 1)) begin
                           busy_o  <= 1'b0;
                           state_q <= SG_IDLE;
                        end else begin
                           pulse_q  <= pulse_q + 1'b1;
                           scl_oe_o <= 1'b1;
                           state_q  <= SG_RCV_LO;
                        end
                     end else begin
                        ph_q <= ph_q + 1'b1;
                     end
                  end
               end
               default: state_q <= SG_IDLE;
            endcase
         end
      end
   end

   assign irq_o = tout_o | berr_o;
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk (
   input logic clk,
   input logic rst_n,
   input logic enable_i,
   input logic req_start_i,
   input logic clr_tout_i,
   input logic busy_o,
   input logic scl_oe_o,
   input logic sda_oe_o,
   input logic tout_o,
   input logic berr_o
);
   // R2
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable_i && req_start_i && !busy_o) |=> busy_o);

   // R3
   start_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe_o) |-> !scl_oe_o);

   // R5
   tout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tout_o) |-> (!busy_o && !scl_oe_o && !sda_oe_o));

   // R7
   berr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(berr_o) |-> (!busy_o && !scl_oe_o && !sda_oe_o));

   // R8
   tout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tout_o && enable_i && !clr_tout_i) |=> tout_o);

   // R9
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (!busy_o && !scl_oe_o && !sda_oe_o && !tout_o && !berr_o));
endmodule

bind i2c_start_gen i2c_start_gen_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable_i    (enable_i),
   .req_start_i (req_start_i),
   .clr_tout_i  (clr_tout_i),
   .busy_o      (busy_o),
   .scl_oe_o    (scl_oe_o),
   .sda_oe_o    (sda_oe_o),
   .tout_o      (tout_o),
   .berr_o      (berr_o)
);

// File: tb/i2c_start_gen_tb.sv
`timescale 1ns/1ps
module i2c_start_gen_tb;
   localparam int ADDR_W = 7, NB_W = 8, FILT_W = 4, LIM_W = 12;
   localparam int TICK_DIV = 4, HOLD_CYC = 8, LOW_CYC = 8, RCV_PULSES = 9;

   logic clk = 1'b0, rst_n = 1'b0;
   logic enable = 1'b1, req_start = 1'b0, req_read = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [NB_W-1:0]   req_nb = '0;
   logic recover = 1'b0, eng_release = 1'b0, idle_probe = 1'b0;
   logic clr_tout = 1'b0, clr_berr = 1'b0;
   logic [FILT_W-1:0] filt_len = '0;
   logic [LIM_W-1:0]  to_limit = '0;
   logic hold_scl = 1'b0, hold_sda = 1'b0;
   logic scl_line, sda_line;
   logic scl_oe, sda_oe, busy, tout, berr, irq, xgo, xrd;
   logic [ADDR_W-1:0] xaddr;
   logic [NB_W-1:0]   xnb;
   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   assign scl_line = ~(scl_oe | hold_scl);
   assign sda_line = ~(sda_oe | hold_sda);

   i2c_start_gen u_dut (
      .clk(clk), .rst_n(rst_n), .enable_i(enable), .req_start_i(req_start),
      .req_read_i(req_read), .req_addr_i(req_addr), .req_nbytes_i(req_nb),
      .recover_i(recover), .eng_release_i(eng_release), .filt_len_i(filt_len),
      .to_limit_i(to_limit), .idle_probe_i(idle_probe), .clr_tout_i(clr_tout),
      .clr_berr_i(clr_berr), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .tout_o(tout),
      .berr_o(berr), .irq_o(irq), .xfer_go_o(xgo), .xfer_read_o(xrd),
      .xfer_addr_o(xaddr), .xfer_nbytes_o(xnb)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_req(input int a, input bit rd, input int nb);
      req_addr  = ADDR_W'(a);
      req_read  = rd;
      req_nb    = NB_W'(nb);
      req_start = 1'b1;
      @(negedge clk);
      req_start = 1'b0;
   endtask

   task automatic run_go(input int maxc, output bit got, output int t_sda,
                         output int t_scl, output bit st_seen);
      bit prev_sda;
      got = 0; t_sda = -1; t_scl = -1; st_seen = 0;
      prev_sda = sda_line;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (sda_oe && t_sda < 0) t_sda = i;
         if (scl_oe && t_scl < 0) t_scl = i;
         if (prev_sda && !sda_line && scl_line) st_seen = 1;
         prev_sda = sda_line;
         if (xgo) begin
            got = 1;
            break;
         end
      end
   endtask

   task automatic release_eng();
      eng_release = 1'b1;
      @(negedge clk);
      eng_release = 1'b0;
   endtask

   initial begin
      repeat (120000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      bit got, st;
      int ts, tc, t0, dly, rises;
      bit prev_oe, sda_seen;
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      check(!scl_oe && !sda_oe, "R1", "lines driven", int'({scl_oe, sda_oe}), 0);
      check(!busy && !tout && !berr && !irq && !xgo, "R1", "status", int'({busy, tout, berr, irq, xgo}), 0);

      // R2 R3 R4: sweep of filter lengths and SCL release delays
      foreach (dly_set[di]) begin end
      for (int fi = 0; fi < 3; fi++) begin
         for (int di = 0; di < 3; di++) begin
            filt_len = (fi == 0) ? 4'd0 : ((fi == 1) ? 4'd3 : 4'd15);
            dly = (di == 0) ? 1 : ((di == 1) ? 37 : int'($urandom_range(60, 220)));
            hold_scl = 1'b1;
            step(20);
            do_req(8 * fi + di + 1, di[0], fi * 3 + di);
            check(busy == 1'b1, "R2", "busy after request with SCL low", int'(busy), 1);
            step(dly);
            check(!sda_oe, "R2", "SDA driven while SCL held", int'(sda_oe), 0);
            hold_scl = 1'b0;
            run_go(400, got, ts, tc, st);
            check(got, "R3", "handoff pulse after release", int'(got), 1);
            check(st, "R3", "START condition on lines", int'(st), 1);
            check(xaddr == ADDR_W'(8 * fi + di + 1) && xrd == di[0] && xnb == NB_W'(fi * 3 + di),
                  "R3", "latched request", int'(xaddr), 8 * fi + di + 1);
            check(tc - ts == HOLD_CYC, "R4", "SDA-to-SCL spacing", tc - ts, HOLD_CYC);
            check(scl_oe && sda_oe, "R3", "lines held in ownership", int'({scl_oe, sda_oe}), 3);
            release_eng();
            check(!busy && !scl_oe && !sda_oe, "R3", "release by engine", int'({busy, scl_oe, sda_oe}), 0);
         end
      end

      // R4 pause: external SCL low in the middle of the hold phase
      filt_len = 4'd0;
      step(10);
      do_req(5, 1'b0, 1);
      t0 = 0;
      while (!sda_oe && t0 < 50) begin @(negedge clk); t0++; end
      step(2);
      hold_scl = 1'b1;
      step(20);
      hold_scl = 1'b0;
      run_go(200, got, ts, tc, st);
      check(got && tc + 22 >= HOLD_CYC + 18, "R4", "hold paused while SCL low", tc + 22, HOLD_CYC + 20);
      check(tc + 22 <= HOLD_CYC + 26, "R4", "hold resumed after release", tc + 22, HOLD_CYC + 20);
      release_eng();

      // R13 request while busy ignored
      hold_scl = 1'b1;
      step(10);
      do_req(33, 1'b1, 7);
      step(5);
      do_req(99, 1'b0, 200);
      step(5);
      hold_scl = 1'b0;
      run_go(200, got, ts, tc, st);
      check(got && xaddr == 7'd33 && xnb == 8'd7 && xrd, "R13", "second request ignored", int'(xaddr), 33);
      release_eng();

      // R5 timeout while SCL held low
      to_limit = 12'd10;
      hold_scl = 1'b1;
      step(10);
      do_req(3, 1'b0, 1);
      t0 = 1;
      while (!tout && t0 < 200) begin @(negedge clk); t0++; end
      check(t0 >= 34 && t0 <= 48, "R5", "timeout latency in cycles", t0, 10 * TICK_DIV);
      check(tout && irq && !busy, "R5", "flag irq busy", int'({tout, irq, busy}), 6);
      check(!scl_oe && !sda_oe && !berr, "R5", "lines released", int'({scl_oe, sda_oe, berr}), 0);
      step(20);
      // R8 sticky, then cleared
      check(tout == 1'b1, "R8", "timeout flag sticky", int'(tout), 1);
      clr_tout = 1'b1;
      step(1);
      clr_tout = 1'b0;
      check(!tout && !irq, "R8", "timeout flag cleared", int'({tout, irq}), 0);

      // R8 set and clear in the same cycle
      clr_tout = 1'b1;
      do_req(4, 1'b0, 1);
      t0 = 0;
      while (busy && t0 < 200) begin @(negedge clk); t0++; end
      check(tout == 1'b1, "R8", "set wins over same-cycle clear", int'(tout), 1);
      step(1);
      check(tout == 1'b0, "R8", "clear one cycle later", int'(tout), 0);
      clr_tout = 1'b0;
      hold_scl = 1'b0;
      step(10);

      // R7 SDA stuck low with SCL high
      hold_sda = 1'b1;
      step(10);
      do_req(6, 1'b0, 2);
      t0 = 1;
      while (!berr && !tout && t0 < 200) begin @(negedge clk); t0++; end
      check(berr && !tout, "R7", "bus error not timeout", int'({berr, tout}), 2);
      check(!busy && !scl_oe && !sda_oe && irq, "R7", "release with irq", int'({busy, scl_oe, sda_oe, irq}), 1);
      hold_sda = 1'b0;
      clr_berr = 1'b1;
      step(1);
      clr_berr = 1'b0;
      check(!berr, "R8", "bus error cleared", int'(berr), 0);

      // R6 limit zero: long hold, no flag, then completes
      to_limit = 12'd0;
      hold_scl = 1'b1;
      step(5);
      do_req(17, 1'b1, 3);
      step(3000);
      check(!tout && !berr && busy, "R6", "no flag with limit 0", int'({tout, berr, busy}), 1);
      hold_scl = 1'b0;
      run_go(200, got, ts, tc, st);
      check(got && xaddr == 7'd17, "R6", "completes after long hold", int'(got), 1);

      // R9 soft reset while owning the bus, then a flag cleared by disable
      enable = 1'b0;
      step(1);
      check(!busy && !scl_oe && !sda_oe, "R9", "disable releases bus", int'({busy, scl_oe, sda_oe}), 0);
      enable = 1'b1;
      to_limit = 12'd5;
      hold_scl = 1'b1;
      step(5);
      do_req(8, 1'b0, 1);
      step(60);
      check(tout == 1'b1, "R9", "timeout before disable", int'(tout), 1);
      enable = 1'b0;
      step(1);
      check(!tout && !irq, "R9", "disable clears flags", int'({tout, irq}), 0);
      enable = 1'b1;
      hold_scl = 1'b0;
      to_limit = 12'd0;
      step(10);
      do_req(9, 1'b0, 1);
      run_go(100, got, ts, tc, st);
      check(got && xaddr == 7'd9, "R9", "works after re-enable", int'(got), 1);
      release_eng();

      // R11 glitch filter rejects a short release
      filt_len = 4'd8;
      hold_scl = 1'b1;
      step(30);
      do_req(10, 1'b0, 1);
      step(5);
      hold_scl = 1'b0;
      step(3);
      hold_scl = 1'b1;
      step(40);
      check(!sda_oe, "R11", "3-cycle glitch filtered", int'(sda_oe), 0);
      hold_scl = 1'b0;
      run_go(200, got, ts, tc, st);
      check(got, "R11", "long release accepted", int'(got), 1);
      release_eng();
      filt_len = 4'd0;
      hold_scl = 1'b1;
      step(10);
      do_req(11, 1'b0, 1);
      step(5);
      hold_scl = 1'b0;
      step(3);
      hold_scl = 1'b1;
      step(10);
      check(sda_oe, "R11", "unfiltered short release starts", int'(sda_oe), 1);
      hold_scl = 1'b0;
      run_go(200, got, ts, tc, st);
      release_eng();

      // R12 idle probe
      idle_probe = 1'b1;
      to_limit = 12'd20;
      step(10);
      do_req(12, 1'b0, 1);
      run_go(300, got, ts, tc, st);
      check(got && ts + 1 >= 76 && ts + 1 <= 90, "R12", "START after idle period", ts + 1, 20 * TICK_DIV);
      release_eng();
      idle_probe = 1'b0;
      step(5);
      do_req(13, 1'b0, 1);
      run_go(300, got, ts, tc, st);
      check(got && ts + 1 <= 4, "R12", "no idle wait without probe", ts + 1, 1);
      release_eng();

      // R10 recovery pulses
      to_limit = 12'd0;
      step(5);
      recover = 1'b1;
      @(negedge clk);
      recover = 1'b0;
      rises = (scl_oe) ? 1 : 0;
      prev_oe = scl_oe;
      sda_seen = sda_oe;
      check(busy, "R10", "busy during recovery", int'(busy), 1);
      t0 = 0;
      while (busy && t0 < 2000) begin
         @(negedge clk);
         if (scl_oe && !prev_oe) rises++;
         prev_oe = scl_oe;
         if (sda_oe) sda_seen = 1;
         t0++;
      end
      check(rises == RCV_PULSES, "R10", "SCL pulse count", rises, RCV_PULSES);
      check(!sda_seen && !busy && !scl_oe, "R10", "SDA untouched and done", int'({sda_seen, busy, scl_oe}), 0);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   int dly_set [3] = '{1, 37, 100};
endmodule